// File: doc/BRIEF.md
# OLED Panel Power-Up Command Sequencer

This block brings a monochrome OLED panel controller out of reset and programs it. After a start pulse it drives the panel's reset line high for a fixed time, releases it, waits the same time again, and then sends an ordered stream of command bytes on a byte-wide channel with a valid/ready handshake. Every byte is tagged as a command through a command/data flag. The serial link that carries the bytes (SPI, I2C or other) sits outside the block and acts as the consumer of the handshake.

The operands of the stream come from configuration inputs: contrast, segment remap and COM scan direction, panel height, display offset, oscillator divider and frequency, the two precharge phases, the COM pin options, VCOMH level, charge-pump need, an optional gamma lookup table of `LUT_LEN` bytes, and the addressing mode. The configuration is captured when the start pulse is accepted. Some commands go out only when an option asks for them. When the last byte has been accepted, a done flag rises and stays high until the next start.

Top module: `oled_init_seq`

## Requirements
- R1: After reset, `panel_rst_o`, `cmd_valid_o`, `busy_o` and `done_o` are all low.
- R2: An accepted start drives `panel_rst_o` high for exactly RST_CYC = (CLK_HZ/1000)*RST_NS/1000000 cycles (200 by default). `cmd_valid_o` then stays low for another RST_CYC cycles before the first byte is offered.
- R3: A byte counts as transferred only on a cycle where `cmd_valid_o` and `cmd_ready_i` are both high. While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` and `cmd_byte_o` keep their values.
- R4: The stream opens with these bytes, in this order: 0x81, contrast; 0xA0 with the segment remap flag in bit 0; 0xC0 with the COM invert flag in bit 3; 0xA8, height−1; 0xD3, display offset; 0xD5.
- R5: The byte after 0xD5 carries (divider−1) in bits 3:0 and the oscillator frequency in bits 7:4.
- R6: The pair 0xD8, mode is sent only when area colour or low power is enabled. The mode byte is 0x1E (when area colour is enabled) ORed with 0x05 (when low power is enabled).
- R7: Next comes 0xD9 with precharge phase 1 in bits 3:0 and phase 2 in bits 7:4. Then comes 0xDA with an operand that has bit 1 set, bit 4 equal to the inverse of the sequential-COM flag, bit 5 equal to the left/right remap flag, and all other bits clear.
- R8: Next comes 0xDB, VCOMH value. Then comes 0x8D with an operand that has bit 4 set, bit 2 equal to the charge-pump flag, and all other bits clear.
- R9: When the lookup table is enabled, 0x91 is sent, followed by the `LUT_LEN` entries with entry 0 first. Entry i is `lut_i[8*i+7:8*i]`. When the table is disabled, none of these bytes is sent.
- R10: The stream ends with 0x20 followed by 0x02 (page mode) or 0x00 (horizontal mode). After that last byte is accepted, `done_o` goes high and `cmd_valid_o` stays low until the next start.
- R11: `dc_o` is 0 (command) on every byte offered.
- R12: A start pulse while `busy_o` is high is ignored. Configuration changes after the start has been accepted do not affect the stream that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted when not busy |
| contrast_i | input | 8 | Contrast level |
| seg_remap_i | input | 1 | Segment remap flag |
| com_invert_i | input | 1 | COM scan direction invert |
| height_i | input | 8 | Panel height in rows (1..255) |
| disp_offset_i | input | 8 | Display vertical offset |
| osc_div_i | input | 5 | Clock divider (1..16) |
| osc_freq_i | input | 4 | Oscillator frequency setting |
| area_color_i | input | 1 | Area colour enable |
| low_power_i | input | 1 | Low-power display enable |
| pre1_i | input | 4 | Precharge phase 1 |
| pre2_i | input | 4 | Precharge phase 2 |
| com_seq_i | input | 1 | Sequential COM pin layout |
| com_lr_i | input | 1 | COM left/right remap |
| vcomh_i | input | 8 | VCOMH deselect level |
| pump_need_i | input | 1 | Charge pump required |
| lut_en_i | input | 1 | Send gamma lookup table |
| lut_i | input | 8*LUT_LEN | Lookup table entries, entry 0 in the low byte |
| page_mode_i | input | 1 | 1 selects page addressing, 0 horizontal |
| panel_rst_o | output | 1 | Panel reset, active high |
| cmd_byte_o | output | 8 | Byte offered to the link |
| cmd_valid_o | output | 1 | Byte valid |
| cmd_ready_i | input | 1 | Link accepts the byte |
| dc_o | output | 1 | Command/data flag, 0 = command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
Two things can land on the same edge. A new start pulse and a byte handshake can coincide, and so can a change of the configuration inputs and a byte handshake. The bench raises `start_i` and scrambles every configuration input in the very cycle in which a chosen byte is accepted. It then judges the rest of the stream against the list computed from the configuration captured at the original start. The bench also fails if `panel_rst_o` rises again or the byte count changes.

// File: rtl/oled_init_pkg.sv
package oled_init_pkg;

    typedef struct packed {
        logic [7:0] contrast;
        logic       seg_remap;
        logic       com_invert;
        logic [7:0] height;
        logic [7:0] disp_offset;
        logic [4:0] osc_div;
        logic [3:0] osc_freq;
        logic       area_color;
        logic       low_power;
        logic [3:0] pre1;
        logic [3:0] pre2;
        logic       com_seq;
        logic       com_lr;
        logic [7:0] vcomh;
        logic       pump_need;
        logic       lut_en;
        logic       page_mode;
    } panel_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RST_HOLD, ST_RST_WAIT, ST_SEND, ST_DONE
    } seq_state_t;

    // Step indices of the fixed part of the stream
    localparam int STEP_AREA_OP = 10;
    localparam int STEP_PRE_OP  = 12;
    localparam int STEP_LUT_OP  = 20;
    localparam int STEP_LUT0    = 21;

    function automatic logic [7:0] fixed_byte(input logic [4:0] idx, input panel_cfg_t c);
        logic [3:0] div_m1;
        div_m1 = 4'(c.osc_div - 5'd1);
        case (idx)
            5'd0:  fixed_byte = 8'h81;
            5'd1:  fixed_byte = c.contrast;
            5'd2:  fixed_byte = {7'b1010_000, c.seg_remap};
            5'd3:  fixed_byte = {4'hC, c.com_invert, 3'b000};
            5'd4:  fixed_byte = 8'hA8;
            5'd5:  fixed_byte = c.height - 8'd1;
            5'd6:  fixed_byte = 8'hD3;
            5'd7:  fixed_byte = c.disp_offset;
            5'd8:  fixed_byte = 8'hD5;
            5'd9:  fixed_byte = {c.osc_freq, div_m1};
            5'd10: fixed_byte = 8'hD8;
            5'd11: fixed_byte = (c.area_color ? 8'h1E : 8'h00) | (c.low_power ? 8'h05 : 8'h00);
            5'd12: fixed_byte = 8'hD9;
            5'd13: fixed_byte = {c.pre2, c.pre1};
            5'd14: fixed_byte = 8'hDA;
            5'd15: fixed_byte = {2'b00, c.com_lr, ~c.com_seq, 2'b00, 1'b1, 1'b0};
            5'd16: fixed_byte = 8'hDB;
            5'd17: fixed_byte = c.vcomh;
            5'd18: fixed_byte = 8'h8D;
            5'd19: fixed_byte = {3'b000, 1'b1, 1'b0, c.pump_need, 2'b00};
            default: fixed_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/oled_rst_timer.sv
module oled_rst_timer #(
    parameter int CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    assign expired = en && (cnt == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || expired) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/oled_step_cursor.sv
module oled_step_cursor
    import oled_init_pkg::*;
#(
    parameter int LUT_LEN = 4,
    parameter int STEP_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              skip_area,
    input  logic              skip_lut,
    output logic [STEP_W-1:0] step,
    output logic              last
);
    localparam int TAIL_STEP = STEP_LUT0 + LUT_LEN;
    localparam int LAST_STEP = TAIL_STEP + 1;

    logic [STEP_W-1:0] nxt;

    assign last = (step == STEP_W'(LAST_STEP));

    always_comb begin
        nxt = step + 1'b1;
        if (nxt == STEP_W'(STEP_AREA_OP) && skip_area) nxt = STEP_W'(STEP_PRE_OP);
        if (nxt == STEP_W'(STEP_LUT_OP)  && skip_lut)  nxt = STEP_W'(TAIL_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst || load)          step <= '0;
        else if (advance && !last) step <= nxt;
    end
endmodule

// File: rtl/oled_byte_builder.sv
module oled_byte_builder
    import oled_init_pkg::*;
#(
    parameter int LUT_LEN = 4,
    parameter int STEP_W  = 5
) (
    input  logic [STEP_W-1:0]    step,
    input  panel_cfg_t           cfg,
    input  logic [8*LUT_LEN-1:0] lut,
    output logic [7:0]           byte_o
);
    localparam int TAIL_STEP = STEP_LUT0 + LUT_LEN;

    always_comb begin
        if (step < STEP_W'(STEP_LUT_OP)) begin
            byte_o = fixed_byte(step[4:0], cfg);
        end else if (step == STEP_W'(STEP_LUT_OP)) begin
            byte_o = 8'h91;
        end else if (step == STEP_W'(TAIL_STEP)) begin
            byte_o = 8'h20;
        end else if (step == STEP_W'(TAIL_STEP + 1)) begin
            byte_o = cfg.page_mode ? 8'h02 : 8'h00;
        end else begin
            byte_o = 8'h00;
            for (int i = 0; i < LUT_LEN; i++) begin
                if (step == STEP_W'(STEP_LUT0 + i)) byte_o = lut[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
    import oled_init_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int RST_NS  = 4000,
    parameter int LUT_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [7:0]           contrast_i,
    input  logic                 seg_remap_i,
    input  logic                 com_invert_i,
    input  logic [7:0]           height_i,
    input  logic [7:0]           disp_offset_i,
    input  logic [4:0]           osc_div_i,
    input  logic [3:0]           osc_freq_i,
    input  logic                 area_color_i,
    input  logic                 low_power_i,
    input  logic [3:0]           pre1_i,
    input  logic [3:0]           pre2_i,
    input  logic                 com_seq_i,
    input  logic                 com_lr_i,
    input  logic [7:0]           vcomh_i,
    input  logic                 pump_need_i,
    input  logic                 lut_en_i,
    input  logic [8*LUT_LEN-1:0] lut_i,
    input  logic                 page_mode_i,
    output logic                 panel_rst_o,
    output logic [7:0]           cmd_byte_o,
    output logic                 cmd_valid_o,
    input  logic                 cmd_ready_i,
    output logic                 dc_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int RST_CYC   = (CLK_HZ / 1000) * RST_NS / 1000000;
    localparam int NUM_STEPS = STEP_LUT0 + LUT_LEN + 2;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    seq_state_t           state;
    panel_cfg_t           cfg_in, cfg_q;
    logic [8*LUT_LEN-1:0] lut_q;
    logic                 tmr_exp, step_last, xfer;
    logic [STEP_W-1:0]    step;

    assign cfg_in = '{contrast: contrast_i, seg_remap: seg_remap_i, com_invert: com_invert_i,
                      height: height_i, disp_offset: disp_offset_i, osc_div: osc_div_i,
                      osc_freq: osc_freq_i, area_color: area_color_i, low_power: low_power_i,
                      pre1: pre1_i, pre2: pre2_i, com_seq: com_seq_i, com_lr: com_lr_i,
                      vcomh: vcomh_i, pump_need: pump_need_i, lut_en: lut_en_i,
                      page_mode: page_mode_i};

    assign panel_rst_o = (state == ST_RST_HOLD);
    assign cmd_valid_o = (state == ST_SEND);
    assign busy_o      = (state == ST_RST_HOLD) || (state == ST_RST_WAIT) || (state == ST_SEND);
    assign done_o      = (state == ST_DONE);
    assign dc_o        = 1'b0;
    assign xfer        = cmd_valid_o && cmd_ready_i;

    oled_rst_timer #(.CYC(RST_CYC)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .en      ((state == ST_RST_HOLD) || (state == ST_RST_WAIT)),
        .expired (tmr_exp)
    );

    oled_step_cursor #(.LUT_LEN(LUT_LEN), .STEP_W(STEP_W)) cur_i (
        .clk       (clk),
        .rst       (rst),
        .load      (state != ST_SEND),
        .advance   (xfer),
        .skip_area (!(cfg_q.area_color || cfg_q.low_power)),
        .skip_lut  (!cfg_q.lut_en),
        .step      (step),
        .last      (step_last)
    );

    oled_byte_builder #(.LUT_LEN(LUT_LEN), .STEP_W(STEP_W)) bld_i (
        .step   (step),
        .cfg    (cfg_q),
        .lut    (lut_q),
        .byte_o (cmd_byte_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            lut_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (start_i) begin
                    cfg_q <= cfg_in;
                    lut_q <= lut_i;
                    state <= ST_RST_HOLD;
                end
                ST_RST_HOLD: if (tmr_exp) state <= ST_RST_WAIT;
                ST_RST_WAIT: if (tmr_exp) state <= ST_SEND;
                ST_SEND:     if (xfer && step_last) state <= ST_DONE;
                default:     state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk #(
    parameter int CLK_HZ = 50_000_000,
    parameter int RST_NS = 4000
) (
    input logic       clk,
    input logic       rst,
    input logic       panel_rst_o,
    input logic       cmd_valid_o,
    input logic       cmd_ready_i,
    input logic [7:0] cmd_byte_o,
    input logic       busy_o,
    input logic       done_o
);
    localparam int RST_CYC = (CLK_HZ / 1000) * RST_NS / 1000000;
    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst || !panel_rst_o) run <= 0;
        else                     run <= run + 1;
    end

    // R3: offered byte held while not accepted
    a_r3_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_byte_o)));

    // R2: no byte offered while the panel is held in reset
    a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        panel_rst_o |-> !cmd_valid_o);

    // R2: reset pulse never longer than RST_CYC
    a_r2_pulse_max: assert property (@(posedge clk) disable iff (rst)
        panel_rst_o |-> (run < RST_CYC));

    // R2: reset pulse never shorter than RST_CYC
    a_r2_pulse_min: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_rst_o) |-> ($past(run) == RST_CYC - 1));

    // R10: finished sequencer is silent
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!cmd_valid_o && !panel_rst_o && !busy_o));
endmodule

bind oled_init_seq oled_init_seq_chk #(.CLK_HZ(CLK_HZ), .RST_NS(RST_NS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .panel_rst_o (panel_rst_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_byte_o  (cmd_byte_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/oled_init_seq_tb_top.sv
module oled_init_seq_tb_top;
    localparam int LUT_LEN = 4;
    localparam int RST_CYC = 200;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start_i;
    logic [7:0] contrast_i, height_i, disp_offset_i, vcomh_i;
    logic seg_remap_i, com_invert_i, area_color_i, low_power_i, com_seq_i, com_lr_i;
    logic pump_need_i, lut_en_i, page_mode_i, cmd_ready_i;
    logic [4:0] osc_div_i;
    logic [3:0] osc_freq_i, pre1_i, pre2_i;
    logic [8*LUT_LEN-1:0] lut_i;
    logic panel_rst_o, cmd_valid_o, dc_o, busy_o, done_o;
    logic [7:0] cmd_byte_o;

    oled_init_seq #(.LUT_LEN(LUT_LEN)) dut_i (.*);

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] exp_b [0:63];
    string      exp_r [0:63];
    int         exp_n;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic add(input logic [7:0] b, input string r);
        exp_b[exp_n] = b;
        exp_r[exp_n] = r;
        exp_n++;
    endtask

    task automatic build_exp();
        exp_n = 0;
        add(8'h81, "R4"); add(contrast_i, "R4");
        add(8'hA0 + {7'd0, seg_remap_i}, "R4");
        add(8'hC0 + (com_invert_i ? 8'd8 : 8'd0), "R4");
        add(8'hA8, "R4"); add(height_i - 8'd1, "R4");
        add(8'hD3, "R4"); add(disp_offset_i, "R4");
        add(8'hD5, "R5");
        add(8'((osc_freq_i * 16) + ((osc_div_i - 1) % 16)), "R5");
        if (area_color_i || low_power_i) begin
            add(8'hD8, "R6");
            add((area_color_i ? 8'h1E : 8'h00) | (low_power_i ? 8'h05 : 8'h00), "R6");
        end
        add(8'hD9, "R7"); add(8'(pre1_i + pre2_i * 16), "R7");
        add(8'hDA, "R7");
        add(8'h02 | (com_seq_i ? 8'h00 : 8'h10) | (com_lr_i ? 8'h20 : 8'h00), "R7");
        add(8'hDB, "R8"); add(vcomh_i, "R8");
        add(8'h8D, "R8"); add(8'h10 | (pump_need_i ? 8'h04 : 8'h00), "R8");
        if (lut_en_i) begin
            add(8'h91, "R9");
            for (int i = 0; i < LUT_LEN; i++) add(lut_i[8*i +: 8], "R9");
        end
        add(8'h20, "R10"); add(page_mode_i ? 8'h02 : 8'h00, "R10");
    endtask

    task automatic rand_cfg();
        contrast_i = 8'($urandom); seg_remap_i = 1'($urandom); com_invert_i = 1'($urandom);
        height_i = 8'(1 + $urandom % 64); disp_offset_i = 8'($urandom);
        osc_div_i = 5'(1 + $urandom % 16); osc_freq_i = 4'($urandom);
        area_color_i = 1'($urandom); low_power_i = 1'($urandom);
        pre1_i = 4'($urandom); pre2_i = 4'($urandom);
        com_seq_i = 1'($urandom); com_lr_i = 1'($urandom); vcomh_i = 8'($urandom);
        pump_need_i = 1'($urandom); lut_en_i = 1'($urandom); page_mode_i = 1'($urandom);
        lut_i = {$urandom, $urandom};
    endtask

    task automatic set_all(input bit v);
        contrast_i = v ? 8'hFF : 8'h00; seg_remap_i = v; com_invert_i = v;
        height_i = v ? 8'd64 : 8'd16; disp_offset_i = v ? 8'h3F : 8'h00;
        osc_div_i = v ? 5'd16 : 5'd1; osc_freq_i = v ? 4'hF : 4'h0;
        area_color_i = v; low_power_i = v; pre1_i = v ? 4'hF : 4'h0; pre2_i = v ? 4'hA : 4'h0;
        com_seq_i = v; com_lr_i = v; vcomh_i = v ? 8'h34 : 8'h00; pump_need_i = v;
        lut_en_i = v; page_mode_i = v; lut_i = v ? 32'h3F2A1F30 : 32'h0;
    endtask

    task automatic run_seq(input int disturb_at);
        int hi, gap, got, cyc;
        bit prev_hold;
        logic [7:0] prev_byte;
        build_exp();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        hi = 0;
        while (panel_rst_o && hi < 1000) begin hi++; @(negedge clk); end
        check(hi == RST_CYC, "R2 reset pulse length", hi, RST_CYC);
        gap = 0;
        while (!cmd_valid_o && gap < 1000) begin gap++; @(negedge clk); end
        check(gap == RST_CYC, "R2 wait after reset", gap, RST_CYC);
        got = 0; cyc = 0; prev_hold = 0; prev_byte = 8'h00;
        while (!done_o && cyc < 2000) begin
            cmd_ready_i = ($urandom % 4) != 0;
            if (prev_hold) begin
                check(cmd_valid_o, "R3 valid held", cmd_valid_o, 1);
                check(cmd_byte_o == prev_byte, "R3 byte held", cmd_byte_o, prev_byte);
            end
            if (panel_rst_o) check(0, "R12 restart during busy", 1, 0);
            if (cmd_valid_o) check(dc_o == 1'b0, "R11 command flag", dc_o, 0);
            if (cmd_valid_o && cmd_ready_i) begin
                if (got < exp_n)
                    check(cmd_byte_o == exp_b[got], {exp_r[got], " byte"}, cmd_byte_o, exp_b[got]);
                else
                    check(0, "R10 extra byte", got, exp_n);
                got++;
                if (got == disturb_at) begin
                    start_i = 1'b1;        // R12: start and config change while busy
                    rand_cfg();
                end
            end
            prev_hold = cmd_valid_o && !cmd_ready_i;
            prev_byte = cmd_byte_o;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(got == exp_n, "R10 byte count", got, exp_n);
        check(done_o, "R10 done", done_o, 1);
        repeat (3) @(negedge clk);
        check(!cmd_valid_o && done_o && !panel_rst_o, "R10 idle after done",
              {cmd_valid_o, done_o, panel_rst_o}, 3'b010);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; cmd_ready_i = 1'b0;
        set_all(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({panel_rst_o, cmd_valid_o, busy_o, done_o} == 4'b0, "R1 reset state",
              {panel_rst_o, cmd_valid_o, busy_o, done_o}, 0);
        set_all(1'b0);           // R6 / R9 skipped commands
        run_seq(-1);
        set_all(1'b1);           // every option on
        run_seq(5);
        for (int k = 0; k < 6; k++) begin
            rand_cfg();
            run_seq(1 + $urandom % 12);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule